// File: doc/BRIEF.md
# Ternary Logic Function Unit

This block evaluates one ternary gate function per clock on radix-3 operands. Each trit is carried on a two-bit binary code. The unit takes three operand trits, a carry-in trit, a multiplexer select trit and a four-bit function code. It returns one result trit, a carry trit and an error flag. The function set is:

- inversion and the three literal detectors
- complement of the maximum and complement of the minimum
- trit multiplication, with and without an added carry-in
- two-way and three-way trit multiplexers

The evaluation logic is purely combinational. It feeds a single output register, so a host datapath sees the result one clock after it presents the operands. Out-of-range trit codes and unassigned function codes do not propagate as garbage. They raise the error flag and force the result and the carry to zero.

Top module: `trit_fu`

## Requirements
- R1: Trit coding is 2'b00 = 0, 2'b01 = 1 and 2'b10 = 2. If any of `in_a`, `in_b`, `in_c`, `cin` or `msel` holds the illegal code 2'b11, then `err` is 1 on the following cycle and `res` and `carry` are both 0.
- R2: Function codes are 0 inversion, 1/2/3 literal detect of 0/1/2, 4 complemented MAX, 5 complemented MIN, 6 multiply, 7 multiply plus carry-in, 8 two-way mux, 9 three-way mux. Codes 10 to 15 set `err` on the next cycle, with `res` and `carry` both 0.
- R3: The outputs are registered and reflect the inputs present at the previous rising edge. While synchronous reset is high, the next edge clears `res`, `carry` and `err` to 0.
- R4: Inversion gives `res` = 2 - a.
- R5: A literal detect of value k gives `res` = 2 when a equals k, and `res` = 0 otherwise.
- R6: Complemented MAX gives `res` = 2 - max(a, b).
- R7: Complemented MIN gives `res` = 2 - min(a, b).
- R8: Multiply gives `res` = (a·b) mod 3 and `carry` = floor(a·b / 3). For example, 2·2 gives `res` 1 and `carry` 1.
- R9: Multiply plus carry-in gives `res` = (a·b + cin) mod 3 and `carry` = floor((a·b + cin) / 3). The carry can reach 2.
- R10: The two-way mux gives `res` = a when `msel` = 0, and `res` = b when `msel` is 1 or 2.
- R11: The three-way mux gives `res` = a, b or c for `msel` = 0, 1 or 2.
- R12: For every function other than the two multiplies, `carry` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fsel | input | 4 | Function code |
| in_a | input | 2 | Operand trit a |
| in_b | input | 2 | Operand trit b |
| in_c | input | 2 | Operand trit c (three-way mux only) |
| cin | input | 2 | Carry-in trit for multiply plus carry |
| msel | input | 2 | Multiplexer select trit |
| res | output | 2 | Registered result trit |
| carry | output | 2 | Registered carry trit |
| err | output | 1 | Registered illegal-input flag |

## Verification
The assertions assume that every input is a known value at each rising edge outside reset, and that inputs change only between edges. They do not assume that trit codes are legal. The illegal code and the unassigned function codes are part of the checked behaviour. The stimulus drives every input on the falling edge and sweeps all 16 function codes against all four codes of every operand, the carry-in and the select. Illegal combinations therefore occur alongside legal ones, and a reset is applied in the middle of the run.

// File: rtl/trit_pkg.sv
package trit_pkg;

    localparam int TRIT_W  = 2;
    localparam int FSEL_W  = 4;
    localparam int FN_USED = 10;
    localparam int SUM_W   = 3;

    typedef logic [TRIT_W-1:0] trit_t;

    localparam trit_t T_ZERO = 2'b00;
    localparam trit_t T_ONE  = 2'b01;
    localparam trit_t T_TWO  = 2'b10;
    localparam trit_t T_BAD  = 2'b11;

    typedef enum logic [FSEL_W-1:0] {
        FN_INV  = 4'd0,
        FN_LIT0 = 4'd1,
        FN_LIT1 = 4'd2,
        FN_LIT2 = 4'd3,
        FN_NMAX = 4'd4,
        FN_NMIN = 4'd5,
        FN_MUL  = 4'd6,
        FN_MULC = 4'd7,
        FN_MUX2 = 4'd8,
        FN_MUX3 = 4'd9
    } fn_e;

    typedef struct packed {
        trit_t res;
        trit_t carry;
        logic  err;
    } fu_out_t;

    function automatic logic t_legal(input trit_t x);
        return x != T_BAD;
    endfunction

    function automatic trit_t t_inv(input trit_t x);
        return T_TWO - x;
    endfunction

    function automatic trit_t t_max(input trit_t x, input trit_t y);
        return (x > y) ? x : y;
    endfunction

    function automatic trit_t t_min(input trit_t x, input trit_t y);
        return (x < y) ? x : y;
    endfunction

    function automatic trit_t t_lit(input trit_t x, input trit_t k);
        return (x == k) ? T_TWO : T_ZERO;
    endfunction

    // Split a small binary sum (0..6) into low trit and carry trit.
    function automatic fu_out_t t_split(input logic [SUM_W-1:0] s);
        fu_out_t o;
        o.err = 1'b0;
        case (s)
            3'd0:    begin o.res = T_ZERO; o.carry = T_ZERO; end
            3'd1:    begin o.res = T_ONE;  o.carry = T_ZERO; end
            3'd2:    begin o.res = T_TWO;  o.carry = T_ZERO; end
            3'd3:    begin o.res = T_ZERO; o.carry = T_ONE;  end
            3'd4:    begin o.res = T_ONE;  o.carry = T_ONE;  end
            3'd5:    begin o.res = T_TWO;  o.carry = T_ONE;  end
            3'd6:    begin o.res = T_ZERO; o.carry = T_TWO;  end
            default: begin o.res = T_ZERO; o.carry = T_ZERO; end
        endcase
        return o;
    endfunction

endpackage

// File: rtl/trit_validate.sv
module trit_validate
    import trit_pkg::*;
#(
    parameter int N_TRITS = 5
) (
    input  logic [N_TRITS*TRIT_W-1:0] trits,
    output logic                      any_bad
);
    logic [N_TRITS-1:0] bad_vec;

    for (genvar i = 0; i < N_TRITS; i++) begin : g_chk
        assign bad_vec[i] = !t_legal(trits[i*TRIT_W +: TRIT_W]);
    end

    assign any_bad = |bad_vec;
endmodule

// File: rtl/trit_gates.sv
module trit_gates
    import trit_pkg::*;
(
    input  logic [FSEL_W-1:0] fsel,
    input  trit_t             a,
    input  trit_t             b,
    output trit_t             y
);
    always_comb begin
        case (fn_e'(fsel))
            FN_INV:  y = t_inv(a);
            FN_LIT0: y = t_lit(a, T_ZERO);
            FN_LIT1: y = t_lit(a, T_ONE);
            FN_LIT2: y = t_lit(a, T_TWO);
            FN_NMAX: y = t_inv(t_max(a, b));
            FN_NMIN: y = t_inv(t_min(a, b));
            default: y = T_ZERO;
        endcase
    end
endmodule

// File: rtl/trit_mul.sv
module trit_mul
    import trit_pkg::*;
(
    input  trit_t   a,
    input  trit_t   b,
    input  trit_t   cin,
    input  logic    use_cin,
    output fu_out_t y
);
    logic [SUM_W-1:0] prod;
    logic [SUM_W-1:0] sum;

    always_comb begin
        prod = SUM_W'({1'b0, a} * {1'b0, b});
        sum  = prod + (use_cin ? SUM_W'(cin) : SUM_W'(0));
        y    = t_split(sum);
    end
endmodule

// File: rtl/trit_mux.sv
module trit_mux
    import trit_pkg::*;
(
    input  trit_t a,
    input  trit_t b,
    input  trit_t c,
    input  trit_t sel,
    input  logic  three_way,
    output trit_t y
);
    always_comb begin
        case (sel)
            T_ZERO:  y = a;
            T_ONE:   y = b;
            T_TWO:   y = three_way ? c : b;
            default: y = T_ZERO;
        endcase
    end
endmodule

// File: rtl/trit_fu.sv
module trit_fu
    import trit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [FSEL_W-1:0] fsel,
    input  logic [TRIT_W-1:0] in_a,
    input  logic [TRIT_W-1:0] in_b,
    input  logic [TRIT_W-1:0] in_c,
    input  logic [TRIT_W-1:0] cin,
    input  logic [TRIT_W-1:0] msel,
    output logic [TRIT_W-1:0] res,
    output logic [TRIT_W-1:0] carry,
    output logic              err
);
    localparam int N_OPS = 5;

    logic    trit_bad;
    logic    fn_bad;
    trit_t   gate_y;
    trit_t   mux_y;
    fu_out_t mul_y;
    fu_out_t nxt;
    fu_out_t q;

    trit_validate #(.N_TRITS(N_OPS)) u_val (
        .trits   ({in_a, in_b, in_c, cin, msel}),
        .any_bad (trit_bad)
    );

    trit_gates u_gates (
        .fsel (fsel),
        .a    (in_a),
        .b    (in_b),
        .y    (gate_y)
    );

    trit_mul u_mul (
        .a       (in_a),
        .b       (in_b),
        .cin     (cin),
        .use_cin (fsel == FN_MULC),
        .y       (mul_y)
    );

    trit_mux u_mux (
        .a         (in_a),
        .b         (in_b),
        .c         (in_c),
        .sel       (msel),
        .three_way (fsel == FN_MUX3),
        .y         (mux_y)
    );

    assign fn_bad = (fsel >= FSEL_W'(FN_USED));

    always_comb begin
        nxt = '0;
        if (trit_bad || fn_bad) begin
            nxt.err = 1'b1;
        end else begin
            case (fn_e'(fsel))
                FN_MUL, FN_MULC:  nxt = mul_y;
                FN_MUX2, FN_MUX3: nxt.res = mux_y;
                default:          nxt.res = gate_y;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    assign res   = q.res;
    assign carry = q.carry;
    assign err   = q.err;
endmodule

// File: rtl/trit_fu_chk.sv
module trit_fu_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] fsel,
    input logic [1:0] in_a,
    input logic [1:0] in_b,
    input logic [1:0] in_c,
    input logic [1:0] cin,
    input logic [1:0] msel,
    input logic [1:0] res,
    input logic [1:0] carry,
    input logic       err
);
    logic legal;
    assign legal = (in_a != 2'b11) && (in_b != 2'b11) && (in_c != 2'b11) &&
                   (cin != 2'b11) && (msel != 2'b11) && (fsel < 4'd10);

    a_r1_bad_operand_flags: assert property (@(posedge clk) disable iff (rst)
        (in_a == 2'b11) |=> err);

    a_r1_err_clears_outputs: assert property (@(posedge clk) disable iff (rst)
        err |-> (res == 2'b00 && carry == 2'b00));

    a_r2_unused_code_flags: assert property (@(posedge clk) disable iff (rst)
        (fsel >= 4'd10) |=> err);

    a_r3_outputs_never_illegal: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> (res != 2'b11 && carry != 2'b11));

    a_r4_inversion: assert property (@(posedge clk) disable iff (rst)
        (legal && fsel == 4'd0) |=> (res == 2'd2 - $past(in_a)));

    a_r10_mux2_low: assert property (@(posedge clk) disable iff (rst)
        (legal && fsel == 4'd8 && msel == 2'd0) |=> (res == $past(in_a)));

    a_r12_no_carry: assert property (@(posedge clk) disable iff (rst)
        (legal && fsel != 4'd6 && fsel != 4'd7) |=> (carry == 2'b00 && !err));
endmodule

bind trit_fu trit_fu_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .fsel  (fsel),
    .in_a  (in_a),
    .in_b  (in_b),
    .in_c  (in_c),
    .cin   (cin),
    .msel  (msel),
    .res   (res),
    .carry (carry),
    .err   (err)
);

// File: tb/trit_fu_tb.sv
module trit_fu_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] fsel = '0;
    logic [1:0] in_a = '0, in_b = '0, in_c = '0, cin = '0, msel = '0;
    logic [1:0] res, carry;
    logic       err;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    trit_fu u_dut (
        .clk(clk), .rst(rst), .fsel(fsel), .in_a(in_a), .in_b(in_b),
        .in_c(in_c), .cin(cin), .msel(msel),
        .res(res), .carry(carry), .err(err)
    );

    int    e_res, e_car, e_err;
    string e_tag;

    task automatic model(input int f, input int a, input int b, input int c,
                         input int ci, input int ms);
        int s;
        e_res = 0; e_car = 0; e_err = 0;
        if (a == 3 || b == 3 || c == 3 || ci == 3 || ms == 3) begin
            e_err = 1; e_tag = "R1"; return;
        end
        if (f >= 10) begin e_err = 1; e_tag = "R2"; return; end
        case (f)
            0: begin e_res = 2 - a; e_tag = "R4"; end
            1, 2, 3: begin e_res = (a == f - 1) ? 2 : 0; e_tag = "R5"; end
            4: begin e_res = 2 - ((a > b) ? a : b); e_tag = "R6"; end
            5: begin e_res = 2 - ((a < b) ? a : b); e_tag = "R7"; end
            6: begin s = a * b; e_res = s % 3; e_car = s / 3; e_tag = "R8"; end
            7: begin s = a * b + ci; e_res = s % 3; e_car = s / 3; e_tag = "R9"; end
            8: begin e_res = (ms == 0) ? a : b; e_tag = "R10"; end
            default: begin
                e_res = (ms == 0) ? a : (ms == 1) ? b : c; e_tag = "R11";
            end
        endcase
        if (f != 6 && f != 7 && e_tag != "R10" && e_tag != "R11") e_tag = {e_tag, "/R12"};
    endtask

    task automatic compare(input string tag, input int xr, input int xc, input int xe);
        n_checks++;
        if (int'(res) != xr || int'(carry) != xc || int'(err) != xe) begin
            n_fail++;
            $display("FAIL %s: res=%0d carry=%0d err=%0d expected res=%0d carry=%0d err=%0d",
                     tag, res, carry, err, xr, xc, xe);
        end
    endtask

    initial begin
        bit have_prev;
        repeat (3) @(negedge clk);
        compare("R3 reset", 0, 0, 0);
        rst = 1'b0;
        have_prev = 0;
        for (int f = 0; f < 16; f++) begin
            for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++)
            for (int c = 0; c < 4; c++)
            for (int ci = 0; ci < 4; ci++)
            for (int ms = 0; ms < 4; ms++) begin
                @(negedge clk);
                if (have_prev) compare(e_tag, e_res, e_car, e_err);
                fsel = 4'(f); in_a = 2'(a); in_b = 2'(b); in_c = 2'(c);
                cin = 2'(ci); msel = 2'(ms);
                model(f, a, b, c, ci, ms);
                have_prev = 1;
            end
            if (f == 7) begin
                // mid-run reset: R3 reset clears outputs despite pending error input
                @(negedge clk);
                compare(e_tag, e_res, e_car, e_err);
                fsel = 4'd15; rst = 1'b1;
                @(negedge clk);
                compare("R3 mid reset", 0, 0, 0);
                rst = 1'b0; have_prev = 0;
            end
        end
        @(negedge clk);
        compare(e_tag, e_res, e_car, e_err);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule